// File: doc/BRIEF.md
# Two-Bank Interleaved Request Dispatcher

This block sits between one processor's load/store port and two independent cache banks. Each incoming request is sent to a bank chosen from its 256-byte line number: even lines go to one bank and odd lines to the other. Each bank keeps its own four-entry queue and serves the entry at its head after a latency that can be set from outside. Because of this, a request to an idle bank can finish before an earlier request that waits on a busy bank.

Ordering is still kept where the program depends on it. Two requests to the same word always map to the same bank, and each bank retires strictly in arrival order. A load therefore returns the value written by the most recent earlier store to that word, even when the store was still queued when the load arrived. Every completion is reported on an observer channel for its bank. The report carries the sequence number, address, type and data, so that an outside checker can tell allowed reordering from forbidden reordering.

Each bank owns a small word store that is cleared at reset. The store holds whole 32-bit words, so a load always returns either the complete old word or the complete new word.

Top module: `bank_dispatch`

## Requirements
- R1: A request whose address bit 8 is 0 is served by bank 0, and a request whose bit 8 is 1 is served by bank 1. Observer channel b only ever reports addresses with bit 8 equal to b.
- R2: Each bank queues at most 4 requests. in_ready is low exactly while the bank selected by in_addr[8] holds 4 entries. A stalled request is accepted on the first edge after the head of that bank retires.
- R3: The head of bank b retires after (latency code + 1) cycles, using lat0_code or lat1_code. A request accepted at edge E into an empty bank is reported from edge E+code+1 for one cycle. Entries queued behind it retire at intervals of code+1 cycles.
- R4: The two banks run independently. A later request to an idle bank completes before an earlier request still waiting in the other bank, and a full bank never blocks requests to the other bank.
- R5: Requests to the same word address complete in the order they were accepted.
- R6: A load reports the data of the most recent earlier store to the same word in acceptance order. This holds even if that store was still pending when the load was accepted. A word never stored since reset reads as zero.
- R7: A store reports its own write data, and a store replaces the whole 32-bit word in one step.
- R8: Accepted requests are numbered 0, 1, 2, … after reset, modulo 256. Each accepted request is reported exactly once, with its own number, address (in_addr) and type (in_we = 1 for a store).
- R9: After reset, in_ready is 1 (both queues are empty) and both out_valid bits are 0.
- R10: A request held off by a full bank takes no sequence number. in_ready for an address in the other bank is 1 while that bank has room.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lat0_code | input | 3 | Bank 0 service latency minus one |
| lat1_code | input | 3 | Bank 1 service latency minus one |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Selected bank has queue room |
| in_we | input | 1 | 1 = store, 0 = load |
| in_addr | input | 11 | Byte address; bit 8 picks the bank, bits 7:2 the word |
| in_wdata | input | 32 | Store data |
| out_valid | output | 2 | Completion pulse, one bit per bank |
| out_seq | output | 16 | Sequence number, bank b in bits [8b+7:8b] |
| out_addr | output | 22 | Address, bank b in bits [11b+10:11b] |
| out_we | output | 2 | Type of the completed request, per bank |
| out_data | output | 64 | Load result or store data, bank b in bits [32b+31:32b] |

## Verification
A request accepted at edge E into an empty bank with code L is due on that bank's observer channel from edge E+L+1. The request queued k places behind it is due (k+1)(L+1) edges after E. A stalled request is taken on the edge after the head of its bank retires. The bench numbers edges with its own counter, drives inputs and samples outputs on falling edges, and compares the recorded acceptance and completion edges with these sums. Load data is checked against a bench memory that is updated in acceptance order. Same-word order is checked against the last sequence number reported for each word.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    parameter int ADDR_W = 11;
    parameter int DATA_W = 32;
    parameter int SEQ_W  = 8;
    parameter int LAT_W  = 3;

    localparam int BANK_BIT = 8;
    localparam int WORD_LSB = 2;
    localparam int IDX_W    = ADDR_W - 1 - WORD_LSB;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } req_t;

    // word index inside one bank: line bits above the bank bit, word bits below it
    function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:BANK_BIT+1], a[BANK_BIT-1:WORD_LSB]};
    endfunction
endpackage

// File: rtl/dsp_word_store.sv
module dsp_word_store
    import dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

    // whole-word update, visible on the next read of the same word
    assert_read_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_idx != $past(wr_idx) || rd_data == $past(wr_data)));
endmodule

// File: rtl/dsp_bank_lane.sv
module dsp_bank_lane
    import dsp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  lat_code,
    input  logic              push,
    input  req_t              push_req,
    output logic              full,
    output logic              done_valid,
    output req_t              done_req,
    output logic [DATA_W-1:0] done_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        req_t [DEPTH-1:0]  slot;
        logic [PTR_W-1:0]  rd;
        logic [PTR_W-1:0]  wr;
        logic [CNT_W-1:0]  cnt;
        logic [LAT_W-1:0]  tmr;
        logic              dv;
        req_t              dr;
        logic [DATA_W-1:0] dd;
    } lane_t;

    lane_t lane_d, lane_q;

    req_t              head;
    logic              retire;
    logic [DATA_W-1:0] rd_data;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head   = lane_q.slot[lane_q.rd];
    assign retire = (lane_q.cnt != '0) && (lane_q.tmr >= lat_code);

    dsp_word_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (retire && head.we),
        .wr_idx  (word_index(head.addr)),
        .wr_data (head.wdata),
        .rd_idx  (word_index(head.addr)),
        .rd_data (rd_data)
    );

    always_comb begin
        lane_d    = lane_q;
        lane_d.dv = 1'b0;
        if (lane_q.cnt != '0) begin
            lane_d.tmr = retire ? '0 : lane_q.tmr + LAT_W'(1);
        end
        if (retire) begin
            lane_d.dv = 1'b1;
            lane_d.dr = head;
            lane_d.dd = head.we ? head.wdata : rd_data;
            lane_d.rd = ptr_next(lane_q.rd);
        end
        if (push) begin
            lane_d.slot[lane_q.wr] = push_req;
            lane_d.wr              = ptr_next(lane_q.wr);
        end
        lane_d.cnt = lane_q.cnt + CNT_W'(push) - CNT_W'(retire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign full       = (lane_q.cnt == CNT_W'(DEPTH));
    assign done_valid = lane_q.dv;
    assign done_req   = lane_q.dr;
    assign done_data  = lane_q.dd;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (lane_q.cnt < CNT_W'(DEPTH)));

    assert_retire_has_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_q.dv |-> ($past(lane_q.cnt) != '0));
endmodule

// File: rtl/bank_dispatch.sv
module bank_dispatch
    import dsp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LAT_W-1:0]      lat0_code,
    input  logic [LAT_W-1:0]      lat1_code,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_we,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [DATA_W-1:0]     in_wdata,
    output logic [1:0]            out_valid,
    output logic [2*SEQ_W-1:0]    out_seq,
    output logic [2*ADDR_W-1:0]   out_addr,
    output logic [1:0]            out_we,
    output logic [2*DATA_W-1:0]   out_data
);
    localparam int BANKS = 2;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BANKS-1:0] lane_full;
    logic             accept;
    logic [LAT_W-1:0] lat_sel [BANKS];
    req_t             new_req;

    assign lat_sel[0] = lat0_code;
    assign lat_sel[1] = lat1_code;

    assign in_ready = !lane_full[in_addr[BANK_BIT]];
    assign accept   = in_valid && in_ready;
    assign new_req  = '{seq: ctl_q.seq, addr: in_addr, we: in_we, wdata: in_wdata};

    always_comb begin
        ctl_d = ctl_q;
        if (accept) ctl_d.seq = ctl_q.seq + SEQ_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        req_t done_req;

        dsp_bank_lane #(.DEPTH(DEPTH)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .lat_code   (lat_sel[b]),
            .push       (accept && (in_addr[BANK_BIT] == 1'(b))),
            .push_req   (new_req),
            .full       (lane_full[b]),
            .done_valid (out_valid[b]),
            .done_req   (done_req),
            .done_data  (out_data[b*DATA_W +: DATA_W])
        );

        assign out_seq[b*SEQ_W +: SEQ_W]    = done_req.seq;
        assign out_addr[b*ADDR_W +: ADDR_W] = done_req.addr;
        assign out_we[b]                    = done_req.we;

        assert_bank_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[b] |-> (out_addr[b*ADDR_W + BANK_BIT] == 1'(b)));
    end
endmodule

// File: tb/bank_dispatch_bench.sv
module bank_dispatch_bench;
    import dsp_pkg::*;

    localparam int CLK_NS = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LAT_W-1:0]    lat0_code = '0, lat1_code = '0;
    logic                in_valid = 1'b0, in_we = 1'b0;
    logic                in_ready;
    logic [ADDR_W-1:0]   in_addr = '0;
    logic [DATA_W-1:0]   in_wdata = '0;
    logic [1:0]          out_valid, out_we;
    logic [2*SEQ_W-1:0]  out_seq;
    logic [2*ADDR_W-1:0] out_addr;
    logic [2*DATA_W-1:0] out_data;

    bank_dispatch u_bank_dispatch (
        .clk(clk), .rst_n(rst_n), .lat0_code(lat0_code), .lat1_code(lat1_code),
        .in_valid(in_valid), .in_ready(in_ready), .in_we(in_we), .in_addr(in_addr),
        .in_wdata(in_wdata), .out_valid(out_valid), .out_seq(out_seq),
        .out_addr(out_addr), .out_we(out_we), .out_data(out_data)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int issued = 0, done_cnt = 0;
    int acc_at [256];
    int done_at [256];
    logic [ADDR_W-1:0] exp_addr [256];
    logic              exp_we [256];
    logic [DATA_W-1:0] exp_data [256];
    logic [DATA_W-1:0] refmem [512];
    int                last_seq [512];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) begin acc_at[i] = -1; done_at[i] = -1; end
        for (int i = 0; i < 512; i++) begin refmem[i] = '0; last_seq[i] = -1; end
        issued = 0;
        done_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_we = we; in_addr = a; in_wdata = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc_at[issued]   = cyc + 1;
        exp_addr[issued] = a;
        exp_we[issued]   = we;
        exp_data[issued] = we ? d : refmem[a >> 2];
        if (we) refmem[a >> 2] = d;
        issued++;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && done_cnt != issued; i++) @(negedge clk);
        chk(done_cnt == issued, "R8 completion count", done_cnt, issued);
    endtask

    // observer scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int b = 0; b < 2; b++) begin
                if (out_valid[b]) begin
                    int s;
                    logic [ADDR_W-1:0] a;
                    logic [DATA_W-1:0] dt;
                    s  = int'(out_seq[b*SEQ_W +: SEQ_W]);
                    a  = out_addr[b*ADDR_W +: ADDR_W];
                    dt = out_data[b*DATA_W +: DATA_W];
                    chk(a[8] == 1'(b), "R1 bank of address", a[8], b);
                    if (s >= issued) begin
                        chk(1'b0, "R8 unknown sequence", s, issued);
                    end else begin
                        chk(a == exp_addr[s], "R8 address", a, exp_addr[s]);
                        chk(out_we[b] == exp_we[s], "R8 type", out_we[b], exp_we[s]);
                        if (exp_we[s]) chk(dt == exp_data[s], "R7 store data", dt, exp_data[s]);
                        else           chk(dt == exp_data[s], "R6 load data", dt, exp_data[s]);
                        chk(last_seq[a >> 2] < s, "R5 same-word order", last_seq[a >> 2], s);
                        last_seq[a >> 2] = s;
                        chk(done_at[s] < 0, "R8 reported once", done_at[s], -1);
                        done_at[s] = cyc;
                        done_cnt++;
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 150000);
        chk(1'b0, "watchdog", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
        chk(out_valid == 2'b00, "R9 no completion after reset", out_valid, 0);

        // R3: head latency and queued spacing for every code in both banks
        for (int b = 0; b < 2; b++) begin
            for (int L = 0; L < 8; L++) begin
                lat0_code = 3'(L);
                lat1_code = 3'(L);
                do_reset();
                for (int k = 0; k < 4; k++)
                    issue(1'b1, ADDR_W'((b << 8) + k * 4), DATA_W'(32'h1000 * L + k + 1));
                drain();
                for (int k = 0; k < 4; k++)
                    chk(done_at[k] - acc_at[0] == (k + 1) * (L + 1), "R3 retire time",
                        done_at[k] - acc_at[0], (k + 1) * (L + 1));
            end
        end

        // R2, R4, R10: full bank 0, bank 1 stays free
        lat0_code = 3'd7;
        lat1_code = 3'd0;
        do_reset();
        for (int k = 0; k < 4; k++) issue(1'b1, ADDR_W'(k * 4), DATA_W'(32'hA0 + k));
        @(negedge clk);
        in_valid = 1'b1; in_we = 1'b0; in_addr = 11'h010;
        #1 chk(in_ready == 1'b0, "R2 full bank stalls", in_ready, 0);
        in_addr = 11'h110;
        #1 chk(in_ready == 1'b1, "R10 other bank ready", in_ready, 1);
        in_valid = 1'b0;
        issue(1'b1, 11'h110, 32'hBEEF_0001);
        issue(1'b0, 11'h004, 32'h0);
        drain();
        chk(done_at[4] < done_at[0], "R4 later odd-line store first", done_at[4], done_at[0]);
        chk(done_at[4] - acc_at[4] == 1, "R4 idle bank latency", done_at[4] - acc_at[4], 1);
        chk(acc_at[5] == acc_at[0] + 9, "R2 stalled accept edge", acc_at[5], acc_at[0] + 9);

        // R5, R6, R7: mixed sweep with several latency pairs
        for (int r = 0; r < 4; r++) begin
            lat0_code = 3'((r * 3 + 1) % 8);
            lat1_code = 3'((r * 5) % 8);
            do_reset();
            for (int i = 0; i < 100; i++) begin
                int line, wo;
                line = (i * 5 + r) % 8;
                wo   = (i / 3) % 4;
                issue(1'((i % 3) != 1), ADDR_W'((line << 8) | (wo << 2)),
                      DATA_W'(32'h9E37_79B9 * (i + 1) + r));
            end
            drain();
        end

        summary();
        $finish;
    end
endmodule